// File: doc/BRIEF.md
# Programmable CRC Calculator

This block computes a running cyclic redundancy check over data written to it by a simple register bus. One register acts as both the data input and the result: each write folds 8, 16 or 32 new bits into the stored CRC, and a read returns the current CRC. The access width is taken from the byte enables, so a stream of any length in bytes can be processed with word writes followed by a half-word or byte write at the end.

The polynomial and its degree (7, 8, 16 or 32) are programmable at run time. Input data can be bit-reversed per byte, per half-word or per word before it enters the calculation. The result can be bit-reversed on read. The start value sits in a register of its own. Writing that register, or writing the self-clearing reload bit in the control register, reloads the CRC. A 32-bit scratch register is not touched by the reload.

The engine folds one byte per clock, most significant bit first. A one-entry buffer lets the bus issue a second data write at once. A read of the result, or a write that would change the configuration, is held off with `ready_o` until the engine has finished.

Top module: `crcp_top`

## Requirements
- R1: After reset the registers read as follows: result (offset 0x00) 0xFFFFFFFF, scratch (0x04) 0x00000000, control (0x08) 0x00000000, start value (0x10) 0xFFFFFFFF and polynomial (0x14) 0x04C11DB7.
- R2: A write to offset 0x00 with byte enables 4'b1111, 4'b0011 or 4'b0001 folds 32, 16 or 8 low data bits into the CRC, MSB first. Per bit: feedback = CRC[n-1] XOR data bit, CRC is shifted left by one and masked to n bits, and the polynomial masked to n bits is XORed in when feedback is 1.
- R3: A write to offset 0x00 with any other byte-enable pattern has no effect. A write to the scratch, control, start-value or polynomial register has no effect unless the byte enables are 4'b1111.
- R4: Control bits [4:3] set the degree n: 0 gives 32, 1 gives 16, 2 gives 8 and 3 gives 7. The result reads back in bits [n-1:0], and all bits above are zero.
- R5: Control bits [6:5] reverse the input: 0 applies no reversal, 1 reverses each byte, 2 reverses each half-word and 3 reverses the whole word. The reversal unit is never wider than the access, so a byte write under modes 2 and 3 is reversed as one byte, and a half-word write under mode 3 as one half-word.
- R6: Control bit 7 makes a read of the result return its n active bits in reversed order, with zeros above. For example, 0x11223344 at n = 32 reads as 0x22CC4488.
- R7: Writing control bit 0 as 1 loads the CRC from the start-value register. Bit 0 always reads as 0, and the scratch register keeps its value.
- R8: Any full-word write to the start-value register also loads the CRC with the written value.
- R9: Each data byte takes one clock cycle. A result read issued right after a byte, half-word or word write that found the engine idle waits 1, 2 or 4 cycles with `ready_o` low.
- R10: While the engine is busy with one write, a second data write is accepted with no wait. A third write waits until the buffered one has moved into the engine.
- R11: Writes to the control, start-value or polynomial register wait while any data is pending. Scratch-register accesses never wait.
- R12: The scratch register stores and returns any full-word value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| be_i | input | 4 | Byte enables of a write |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Read data for the addressed register |
| ready_o | output | 1 | Access completes at the next clock edge when high |

## Verification
All results can be predicted by counting cycles. A data write accepted at edge E leaves the CRC final after E+1, E+2 or E+4 for a byte, half-word or word, plus four more edges per word waiting in the buffer. Start-value loads and reloads are visible at the edge right after the write. The bench issues each read straight after the write that precedes it and counts the falling edges on which `ready_o` is low, so it checks the stall length (1, 2, 4, 7 or 3 cycles in the buffered cases) as well as the returned value. Every sample is taken 1 ns after a falling edge, when the combinational `ready_o` and `rdata_o` have settled.

// File: rtl/crcp_pkg.sv
package crcp_pkg;
  localparam int DATA_W    = 32;
  localparam int STEP_W    = 8;
  localparam int MAX_STEPS = DATA_W / STEP_W;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);
  localparam int BE_W      = DATA_W / 8;

  localparam logic [7:0] OFS_DR   = 8'h00;
  localparam logic [7:0] OFS_IDR  = 8'h04;
  localparam logic [7:0] OFS_CR   = 8'h08;
  localparam logic [7:0] OFS_INIT = 8'h10;
  localparam logic [7:0] OFS_POL  = 8'h14;

  typedef enum logic [1:0] {
    PSZ_32 = 2'b00, PSZ_16 = 2'b01, PSZ_8 = 2'b10, PSZ_7 = 2'b11
  } psize_e;

  typedef enum logic [1:0] {
    RIN_NONE = 2'b00, RIN_BYTE = 2'b01, RIN_HALF = 2'b10, RIN_WORD = 2'b11
  } rin_e;

  function automatic int size_bits(psize_e s);
    case (s)
      PSZ_32:  return 32;
      PSZ_16:  return 16;
      PSZ_8:   return 8;
      default: return 7;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(psize_e s);
    case (s)
      PSZ_32:  return 32'hFFFF_FFFF;
      PSZ_16:  return 32'h0000_FFFF;
      PSZ_8:   return 32'h0000_00FF;
      default: return 32'h0000_007F;
    endcase
  endfunction

  // reverse bit order inside units of 8/16/32 bits
  function automatic logic [DATA_W-1:0] rev_units(logic [DATA_W-1:0] d, rin_e m);
    logic [DATA_W-1:0] r;
    int u;
    case (m)
      RIN_BYTE: u = 8;
      RIN_HALF: u = 16;
      RIN_WORD: u = 32;
      default:  u = 1;
    endcase
    for (int i = 0; i < DATA_W; i++) r[i] = d[(i / u) * u + (u - 1) - (i % u)];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] crc_step(logic [DATA_W-1:0] c, logic [STEP_W-1:0] d,
                                                 logic [DATA_W-1:0] p, psize_e s);
    logic [DATA_W-1:0] m;
    logic [DATA_W-1:0] v;
    int top;
    logic fb;
    m   = size_mask(s);
    top = size_bits(s) - 1;
    v   = c;
    for (int b = STEP_W - 1; b >= 0; b--) begin
      fb = v[top] ^ d[b];
      v  = (v << 1) & m;
      if (fb) v = v ^ (p & m);
    end
    return v;
  endfunction
endpackage

// File: rtl/crcp_in_fmt.sv
module crcp_in_fmt
  import crcp_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [BE_W-1:0]   be_i,
  input  rin_e              mode_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  steps_o,
  output logic [DATA_W-1:0] aligned_o
);
  logic [DATA_W-1:0] r_byte, r_half, r_word;
  rin_e mode_b, mode_h;

  // reversal unit capped at the access width
  assign mode_b = (mode_i == RIN_NONE) ? RIN_NONE : RIN_BYTE;
  assign mode_h = (mode_i == RIN_WORD) ? RIN_HALF : mode_i;
  assign r_byte = rev_units(data_i, mode_b);
  assign r_half = rev_units(data_i, mode_h);
  assign r_word = rev_units(data_i, mode_i);

  always_comb begin
    valid_o   = 1'b1;
    steps_o   = '0;
    aligned_o = '0;
    case (be_i)
      4'b0001: begin steps_o = CNT_W'(1); aligned_o = {r_byte[7:0],  24'b0}; end
      4'b0011: begin steps_o = CNT_W'(2); aligned_o = {r_half[15:0], 16'b0}; end
      4'b1111: begin steps_o = CNT_W'(MAX_STEPS); aligned_o = r_word; end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crcp_engine.sv
module crcp_engine
  import crcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] poly_i,
  input  psize_e            psize_i,
  input  logic [DATA_W-1:0] rst_val_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [CNT_W-1:0]  push_steps_i,
  output logic              busy_o,
  output logic              full_o,
  output logic [DATA_W-1:0] crc_o
);
  logic [DATA_W-1:0] crc_q, sh_q, buf_data_q, step_val;
  logic [CNT_W-1:0]  cnt_q, buf_steps_q;
  logic              buf_v_q;

  assign step_val = crc_step(crc_q, sh_q[DATA_W-1 -: STEP_W], poly_i, psize_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q       <= rst_val_i;
      sh_q        <= '0;
      cnt_q       <= '0;
      buf_data_q  <= '0;
      buf_steps_q <= '0;
      buf_v_q     <= 1'b0;
    end else begin
      if (ld_i)             crc_q <= ld_val_i;
      else if (cnt_q != '0) crc_q <= step_val;

      if (cnt_q == '0) begin
        if (push_i) begin
          sh_q  <= push_data_i;
          cnt_q <= push_steps_i;
        end
      end else if (cnt_q == CNT_W'(1)) begin
        if (buf_v_q) begin
          sh_q    <= buf_data_q;
          cnt_q   <= buf_steps_q;
          buf_v_q <= 1'b0;
        end else if (push_i) begin
          sh_q  <= push_data_i;
          cnt_q <= push_steps_i;
        end else begin
          cnt_q <= '0;
        end
      end else begin
        sh_q  <= sh_q << STEP_W;
        cnt_q <= cnt_q - CNT_W'(1);
        if (push_i) begin
          buf_data_q  <= push_data_i;
          buf_steps_q <= push_steps_i;
          buf_v_q     <= 1'b1;
        end
      end
    end
  end

  assign busy_o = (cnt_q != '0);
  assign full_o = buf_v_q;
  assign crc_o  = crc_q;

  a_r10_buf_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_v_q |-> (cnt_q != '0));
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !buf_v_q);
  a_r9_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_STEPS));
  a_r9_push_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> busy_o);
endmodule

// File: rtl/crcp_out_fmt.sv
module crcp_out_fmt
  import crcp_pkg::*;
(
  input  logic [DATA_W-1:0] crc_i,
  input  psize_e            psize_i,
  input  logic              rev_i,
  output logic [DATA_W-1:0] dr_o
);
  logic [DATA_W-1:0] masked, rev_full;

  assign masked   = crc_i & size_mask(psize_i);
  assign rev_full = rev_units(masked, RIN_WORD);
  assign dr_o     = rev_i ? (rev_full >> (DATA_W - size_bits(psize_i))) : masked;
endmodule

// File: rtl/crcp_top.sv
module crcp_top
  import crcp_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [DATA_W-1:0] INIT_RST = 32'hFFFF_FFFF,
  parameter logic [DATA_W-1:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  logic [DATA_W-1:0] idr_q, init_q, pol_q;
  logic              rev_out_q;
  rin_e              rev_in_q;
  psize_e            psize_q;

  logic is_dr, is_idr, is_cr, is_init, is_pol, full_word;
  logic fmt_valid, busy, full, pending, stall, fire, push, ld;
  logic [CNT_W-1:0]  fmt_steps;
  logic [DATA_W-1:0] fmt_data, ld_val, crc_w, dr_w;

  assign is_dr     = addr_i == ADDR_W'(OFS_DR);
  assign is_idr    = addr_i == ADDR_W'(OFS_IDR);
  assign is_cr     = addr_i == ADDR_W'(OFS_CR);
  assign is_init   = addr_i == ADDR_W'(OFS_INIT);
  assign is_pol    = addr_i == ADDR_W'(OFS_POL);
  assign full_word = be_i == '1;

  crcp_in_fmt u_in (
    .data_i    (wdata_i),
    .be_i      (be_i),
    .mode_i    (rev_in_q),
    .valid_o   (fmt_valid),
    .steps_o   (fmt_steps),
    .aligned_o (fmt_data)
  );

  assign pending = busy | full;
  assign stall   = req_i & ((is_dr & ~we_i & pending)
                          | (is_dr & we_i & fmt_valid & full)
                          | (we_i & (is_cr | is_init | is_pol) & pending));
  assign ready_o = ~stall;
  assign fire    = req_i & ~stall;
  assign push    = fire & we_i & is_dr & fmt_valid;
  assign ld      = fire & we_i & full_word & (is_init | (is_cr & wdata_i[0]));
  assign ld_val  = is_init ? wdata_i : init_q;

  crcp_engine u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .poly_i       (pol_q),
    .psize_i      (psize_q),
    .rst_val_i    (INIT_RST),
    .ld_i         (ld),
    .ld_val_i     (ld_val),
    .push_i       (push),
    .push_data_i  (fmt_data),
    .push_steps_i (fmt_steps),
    .busy_o       (busy),
    .full_o       (full),
    .crc_o        (crc_w)
  );

  crcp_out_fmt u_out (
    .crc_i   (crc_w),
    .psize_i (psize_q),
    .rev_i   (rev_out_q),
    .dr_o    (dr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idr_q     <= '0;
      init_q    <= INIT_RST;
      pol_q     <= POLY_RST;
      rev_out_q <= 1'b0;
      rev_in_q  <= RIN_NONE;
      psize_q   <= PSZ_32;
    end else if (fire && we_i && full_word) begin
      if (is_idr)  idr_q  <= wdata_i;
      if (is_init) init_q <= wdata_i;
      if (is_pol)  pol_q  <= wdata_i;
      if (is_cr) begin
        rev_out_q <= wdata_i[7];
        rev_in_q  <= rin_e'(wdata_i[6:5]);
        psize_q   <= psize_e'(wdata_i[4:3]);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_dr)   rdata_o = dr_w;
    if (is_idr)  rdata_o = idr_q;
    if (is_cr)   rdata_o = {24'b0, rev_out_q, rev_in_q, psize_q, 3'b000};
    if (is_init) rdata_o = init_q;
    if (is_pol)  rdata_o = pol_q;
  end

  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && is_dr && ready_o) |-> ((rdata_o & ~size_mask(psize_q)) == '0));
  a_r7_reset_bit_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && is_cr) |-> (rdata_o[0] == 1'b0));
  a_r8_init_loads_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && we_i && is_init && full_word) |=> (crc_w == $past(wdata_i)));
  a_r11_poly_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending |=> $stable(pol_q));
  a_r11_idr_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_idr) |-> ready_o);
endmodule

// File: tb/sim_crcp_top.sv
`timescale 1ns/1ps
module sim_crcp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  crcp_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready)
  );

  // reference model
  logic [31:0] m_crc;
  logic [31:0] m_pol;
  int          m_sz;

  function automatic logic [31:0] msk(int sz);
    return (sz == 32) ? 32'hFFFF_FFFF : ((32'h1 << sz) - 1);
  endfunction

  function automatic logic [31:0] fold(logic [31:0] c, logic [31:0] d, int nb, logic [31:0] p, int sz);
    logic fb;
    for (int i = nb - 1; i >= 0; i--) begin
      fb = c[sz-1] ^ d[i];
      c  = (c << 1) & msk(sz);
      if (fb) c = c ^ (p & msk(sz));
    end
    return c;
  endfunction

  function automatic logic [31:0] flip(logic [31:0] d, int w, int g);
    logic [31:0] r = '0;
    int u;
    if (g == 0) return d;
    u = (g == 1) ? 8 : (g == 2) ? 16 : 32;
    if (u > w) u = w;
    for (int i = 0; i < w; i++) r[i] = d[i - (i % u) + u - 1 - (i % u)];
    return r;
  endfunction

  function automatic logic [31:0] view(logic [31:0] c, int sz, bit rv);
    logic [31:0] v = c & msk(sz);
    logic [31:0] r = '0;
    if (!rv) return v;
    for (int i = 0; i < sz; i++) r[i] = v[sz-1-i];
    return r;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after completion
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b, output int st);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b; st = 0;
    #1;
    while (!ready) begin @(negedge clk); #1; st++; end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output int st);
    req = 1'b1; we = 1'b0; addr = a; be = 4'h0; st = 0;
    #1;
    while (!ready) begin @(negedge clk); #1; st++; end
    d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic dwr(input logic [31:0] d, input int w, input int g, output int st);
    logic [3:0] b = (w == 8) ? 4'b0001 : (w == 16) ? 4'b0011 : 4'b1111;
    wr(8'h00, d, b, st);
    m_crc = fold(m_crc, flip(d & msk(w), w, g), w, m_pol, m_sz);
  endtask

  task automatic t_reset();
    logic [31:0] v; int st;
    rd(8'h00, v, st); chk("R1 result reset", v, 32'hFFFF_FFFF);
    rd(8'h04, v, st); chk("R1 scratch reset", v, 32'h0);
    rd(8'h08, v, st); chk("R1 control reset", v, 32'h0);
    rd(8'h10, v, st); chk("R1 start reset", v, 32'hFFFF_FFFF);
    rd(8'h14, v, st); chk("R1 poly reset", v, 32'h04C1_1DB7);
    m_crc = 32'hFFFF_FFFF; m_pol = 32'h04C1_1DB7; m_sz = 32;
  endtask

  task automatic t_widths();
    logic [31:0] v; int st;
    dwr(32'h1234_5678, 32, 0, st);
    rd(8'h00, v, st); chk("R2 word fold", v, m_crc); chk("R9 word wait", st, 4);
    dwr(32'hFFFF_ABCD, 16, 0, st);
    rd(8'h00, v, st); chk("R2 half fold", v, m_crc); chk("R9 half wait", st, 2);
    dwr(32'h0000_005A, 8, 0, st);
    rd(8'h00, v, st); chk("R2 byte fold", v, m_crc); chk("R9 byte wait", st, 1);
  endtask

  task automatic t_ignored();
    logic [31:0] v; int st;
    wr(8'h00, 32'hDEAD_0001, 4'b0110, st);
    rd(8'h00, v, st); chk("R3 odd enables ignored", v, m_crc); chk("R3 no wait", st, 0);
    wr(8'h14, 32'h0000_1234, 4'b0011, st);
    rd(8'h14, v, st); chk("R3 partial poly write ignored", v, 32'h04C1_1DB7);
  endtask

  task automatic t_sizes();
    logic [31:0] v; int st;
    logic [31:0] pols [3] = '{32'h0000_1021, 32'h0000_0007, 32'h0000_0009};
    int szs [3] = '{16, 8, 7};
    for (int k = 0; k < 3; k++) begin
      wr(8'h14, pols[k], 4'hF, st);
      wr(8'h08, (k + 1) << 3, 4'hF, st);
      wr(8'h10, 32'hFFFF_FFFF, 4'hF, st);
      m_pol = pols[k]; m_sz = szs[k]; m_crc = 32'hFFFF_FFFF;
      dwr(32'hC3A5_0F96, 32, 0, st);
      dwr(32'h0000_0042, 8, 0, st);
      rd(8'h00, v, st);
      chk($sformatf("R4 size %0d result", szs[k]), v, m_crc & msk(szs[k]));
    end
    wr(8'h14, 32'h04C1_1DB7, 4'hF, st);
    wr(8'h08, 32'h0, 4'hF, st);
    m_pol = 32'h04C1_1DB7; m_sz = 32;
  endtask

  task automatic t_rev_in();
    logic [31:0] v; int st;
    wr(8'h10, 32'hFFFF_FFFF, 4'hF, st);
    for (int g = 1; g < 4; g++) begin
      wr(8'h08, (g << 5) | 1, 4'hF, st);
      m_crc = 32'hFFFF_FFFF;
      dwr(32'h1A2B_3C4D, 32, g, st);
      dwr(32'h0000_1234, 16, g, st);
      dwr(32'h0000_0081, 8, g, st);
      rd(8'h00, v, st);
      chk($sformatf("R5 input reversal mode %0d", g), v, m_crc);
    end
    wr(8'h08, 32'h0, 4'hF, st);
  endtask

  task automatic t_rev_out();
    logic [31:0] v; int st;
    wr(8'h10, 32'h1122_3344, 4'hF, st);
    rd(8'h00, v, st); chk("R8 start write loads result", v, 32'h1122_3344);
    wr(8'h08, 32'h80, 4'hF, st);
    rd(8'h00, v, st); chk("R6 reversed 32-bit read", v, 32'h22CC_4488);
    wr(8'h08, 32'h98, 4'hF, st);
    wr(8'h10, 32'hFFFF_FF05, 4'hF, st);
    rd(8'h00, v, st); chk("R6 reversed 7-bit read", v, 32'h0000_0050);
    chk("R6 model agrees", v, view(32'hFFFF_FF05, 7, 1));
    wr(8'h08, 32'h0, 4'hF, st);
  endtask

  task automatic t_reload();
    logic [31:0] v; int st;
    wr(8'h04, 32'hDEAD_BEEF, 4'hF, st);
    rd(8'h04, v, st); chk("R12 scratch store", v, 32'hDEAD_BEEF);
    wr(8'h10, 32'h0F0F_0F0F, 4'hF, st);
    m_crc = 32'h0F0F_0F0F;
    dwr(32'h0000_00C7, 8, 0, st);
    wr(8'h08, 32'h1, 4'hF, st);
    rd(8'h00, v, st); chk("R7 reload from start value", v, 32'h0F0F_0F0F);
    rd(8'h04, v, st); chk("R7 scratch untouched", v, 32'hDEAD_BEEF);
    rd(8'h08, v, st); chk("R7 reload bit reads zero", v, 32'h0);
    m_crc = 32'h0F0F_0F0F;
  endtask

  task automatic t_buffer();
    logic [31:0] v; int st;
    wr(8'h10, 32'hFFFF_FFFF, 4'hF, st);
    m_crc = 32'hFFFF_FFFF;
    dwr(32'hA5A5_0001, 32, 0, st); chk("R10 first write no wait", st, 0);
    dwr(32'h5A5A_0002, 32, 0, st); chk("R10 second write no wait", st, 0);
    dwr(32'h3C3C_0003, 32, 0, st); chk("R10 third write waits", st, 3);
    rd(8'h00, v, st); chk("R9 buffered result", v, m_crc); chk("R9 buffered wait", st, 7);
    dwr(32'h0BAD_F00D, 32, 0, st);
    wr(8'h04, 32'h1357_9BDF, 4'hF, st); chk("R11 scratch write no wait", st, 0);
    wr(8'h08, 32'h0, 4'hF, st); chk("R11 control write waits", st, 3);
    rd(8'h00, v, st); chk("R11 result after held write", v, m_crc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_widths();
    t_ignored();
    t_sizes();
    t_rev_in();
    t_rev_out();
    t_reload();
    t_buffer();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule